// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block is the digital half of a 10-bit, eight-input successive-approximation converter inside a microcontroller. Software reaches it through two write ports: a control byte and a prescale byte. The control byte holds the input select, the start bit, the end-of-conversion flag and the interrupt enable. The analog multiplexer, the DAC and the comparator sit outside the block. The block drives the held channel number and the trial DAC code to them, and it reads back one comparator bit.

A conversion makes ten bit-decisions, most significant bit first, with one decision per tick of a divided clock. When the last decision is made, the 10-bit result is loaded into a high part of 8 bits and a low part of 2 bits. In the same cycle the done flag is raised, the start bit drops, and an interrupt is requested if it is enabled.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A control write with bit 3 set while idle starts a conversion. Control readback bit 3 reads 1 while the conversion runs and returns to 0 on its own when the conversion ends.
- R2: Control readback bit 4 (done) sets in the same cycle that the result outputs load. It stays set until a control write with bit 4 equal to 0.
- R3: `irq` is high exactly while done is set and the enable (control bit 5) is 1. Clearing done drops `irq`, and this re-arms it for the next conversion.
- R4: Control bits [2:0] select the input. Code k drives `sel_ch` = k (AN0 to AN7) for the whole conversion.
- R5: With a prescale value P > 0, each decision takes 2·P clock cycles. A conversion lasts 20·P cycles from the start write to done.
- R6: With prescale value 0, each decision takes 64 cycles, so a conversion lasts 640 cycles.
- R7: The result equals the analog code clamped to 10 bits. An input at or above the reference gives 0x3FF, an input at zero gives 0x000, and inputs in between give their own code. `res_hi` holds result bits [9:2] and `res_lo` holds bits [1:0].
- R8: Decisions go from MSB to LSB. The first trial code after a start is 0x200. A bit is kept when `cmp_in` is 1, meaning the input is at or above the DAC level.
- R9: Changing the channel field during a conversion does not change `sel_ch` or the result of that conversion.
- R10: A start write during a running conversion is ignored. The running conversion keeps its original end time.
- R11: Reset clears the control bits, done, the prescale value, the result and the trial code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [2:0] channel, [3] start, [4] done (write 0 clears), [5] interrupt enable |
| prs_we | input | 1 | Prescale write strobe |
| prs_wdata | input | PRS_W | Prescale value |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| ctl_q | output | 8 | Control readback: [2:0] channel, [3] busy/start, [4] done, [5] enable |
| prs_q | output | PRS_W | Prescale readback |
| res_hi | output | RES_W-2 | Result bits [9:2] |
| res_lo | output | 2 | Result bits [1:0] |
| sel_ch | output | 3 | Channel held for the running conversion |
| dac_code | output | RES_W | Trial code driven to the DAC |
| irq | output | 1 | Interrupt request |

## Verification
The bench models each of the eight inputs as a code, and compares that code against `dac_code`. Every non-selected input is set to a decoy value, so a wrong channel shows up as a wrong result. The inputs tried are zero, one, the midpoint, the code just below the midpoint, an uneven mid-scale code, exactly full scale and above full scale. This covers clamping, the MSB decision and the LSB decision. Prescale values of 0 through 4 tell the fixed divide apart from the 2·P divide by the measured conversion length. Directed cases change the channel mid-conversion, issue a second start, and leave done set with the interrupt disabled and then enabled.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W = 10,
  parameter int PRS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             prs_we,
  input  logic [PRS_W-1:0] prs_wdata,
  input  logic             cmp_in,
  output logic [7:0]       ctl_q,
  output logic [PRS_W-1:0] prs_q,
  output logic [RES_W-3:0] res_hi,
  output logic [1:0]       res_lo,
  output logic [2:0]       sel_ch,
  output logic [RES_W-1:0] dac_code,
  output logic             irq
);
  localparam int DIV_W = (PRS_W + 1 > 7) ? PRS_W + 1 : 7;
  localparam int IDX_W = $clog2(RES_W);

  logic [2:0]       chan_r, ch_hold;
  logic             busy, done, ien;
  logic [PRS_W-1:0] prs;
  logic [DIV_W-1:0] cnt, div;
  logic [RES_W-1:0] sar, sar_nx, res;
  logic [IDX_W-1:0] bidx;
  logic             tick, start_go;

  assign div      = (prs == '0) ? DIV_W'(64) : DIV_W'({prs, 1'b0});
  assign tick     = busy && (cnt == div - 1'b1);
  assign start_go = ctl_we && ctl_wdata[3] && !busy;

  always_comb begin
    sar_nx = sar;
    sar_nx[bidx] = cmp_in;
    if (bidx != '0) sar_nx[bidx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_r  <= '0;
      ch_hold <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ien     <= 1'b0;
      prs     <= '0;
      cnt     <= '0;
      sar     <= '0;
      res     <= '0;
      bidx    <= '0;
    end else begin
      if (prs_we) prs <= prs_wdata;
      if (ctl_we) begin
        chan_r <= ctl_wdata[2:0];
        ien    <= ctl_wdata[5];
        if (!ctl_wdata[4]) done <= 1'b0;
      end
      if (start_go) begin
        busy    <= 1'b1;
        ch_hold <= ctl_wdata[2:0];
        sar     <= RES_W'(1) << (RES_W - 1);
        bidx    <= IDX_W'(RES_W - 1);
        cnt     <= '0;
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          sar <= sar_nx;
          if (bidx == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
            res  <= sar_nx;
          end else begin
            bidx <= bidx - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ctl_q    = {2'b00, ien, done, busy, chan_r};
  assign prs_q    = prs;
  assign res_hi   = res[RES_W-1:2];
  assign res_lo   = res[1:0];
  assign sel_ch   = ch_hold;
  assign dac_code = sar;
  assign irq      = ien & done;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int PRS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctl_q,
  input logic [RES_W-3:0] res_hi,
  input logic [1:0]       res_lo,
  input logic [2:0]       sel_ch,
  input logic [RES_W-1:0] dac_code,
  input logic             irq
);
  logic [RES_W-1:0] res_all;
  assign res_all = {res_hi, res_lo};

  assert_busy_ends_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[3]) |-> ctl_q[4]);

  assert_result_loads_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_all) |-> $rose(ctl_q[4]));

  assert_irq_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_q[4] && ctl_q[5]));

  assert_first_trial_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[3]) |-> dac_code == (RES_W'(1) << (RES_W - 1)));

  assert_channel_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[3] && $past(ctl_q[3])) |-> $stable(sel_ch));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W), .PRS_W(PRS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .res_hi(res_hi), .res_lo(res_lo),
  .sel_ch(sel_ch), .dac_code(dac_code), .irq(irq)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, prs_we = 1'b0;
  logic [7:0] ctl_wdata = '0, prs_wdata = '0;
  logic cmp_in;
  logic [7:0] ctl_q, prs_q, res_hi;
  logic [1:0] res_lo;
  logic [2:0] sel_ch;
  logic [9:0] dac_code;
  logic irq;
  logic [10:0] vin [8];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin[sel_ch] >= {1'b0, dac_code});

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prs_we(prs_we), .prs_wdata(prs_wdata), .cmp_in(cmp_in),
    .ctl_q(ctl_q), .prs_q(prs_q), .res_hi(res_hi), .res_lo(res_lo),
    .sel_ch(sel_ch), .dac_code(dac_code), .irq(irq)
  );

  // {channel[3], prescale[8], input code[11]}
  localparam logic [21:0] VEC [7] = '{
    {3'd0, 8'd1, 11'd0},
    {3'd1, 8'd2, 11'd1023},
    {3'd2, 8'd0, 11'd1500},
    {3'd3, 8'd3, 11'd512},
    {3'd5, 8'd1, 11'd511},
    {3'd7, 8'd4, 11'd341},
    {3'd6, 8'd1, 11'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_prs(input logic [7:0] d);
    @(negedge clk); prs_we = 1'b1; prs_wdata = d;
    @(negedge clk); prs_we = 1'b0;
  endtask

  task automatic wait_done(inout int n);
    while (!ctl_q[4] && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 8; i++) vin[i] = 11'd700;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ctl", ctl_q, 0);
    chk("R11 res", {res_hi, res_lo}, 0);
    chk("R11 prs", prs_q, 0);
    chk("R11 dac", dac_code, 0);
    chk("R11 irq", irq, 0);

    foreach (VEC[i]) begin
      logic [2:0] ch = VEC[i][21:19];
      logic [7:0] p  = VEC[i][18:11];
      logic [10:0] v = VEC[i][10:0];
      int expc = (p == 0) ? 640 : 20 * p;
      int expr = (v > 1023) ? 1023 : v;
      for (int k = 0; k < 8; k++) vin[k] = 11'd700;
      vin[ch] = v;
      wr_prs(p);
      wr_ctl({2'b00, 1'b1, 1'b0, 1'b1, ch});
      n = 0;
      chk("R4 sel_ch", sel_ch, ch);
      chk("R8 first trial", dac_code, 10'h200);
      chk("R1 busy", ctl_q[3], 1);
      wait_done(n);
      chk(p == 0 ? "R6 cycles" : "R5 cycles", n, expc);
      chk("R7 result", {res_hi, res_lo}, expr);
      chk("R1 busy cleared", ctl_q[3], 0);
      chk("R3 irq", irq, 1);
    end

    // R3 / R2: interrupt disabled, done held, then enabled, then cleared
    for (int k = 0; k < 8; k++) vin[k] = 11'd300;
    wr_prs(8'd1);
    wr_ctl(8'b0000_1100);
    n = 0; wait_done(n);
    chk("R3 irq disabled", irq, 0);
    repeat (50) @(negedge clk);
    chk("R2 done held", ctl_q[4], 1);
    wr_ctl(8'b0011_0100);
    chk("R3 irq enabled later", irq, 1);
    wr_ctl(8'b0010_0100);
    chk("R2 done cleared", ctl_q[4], 0);
    chk("R3 irq dropped", irq, 0);

    // R9 channel change mid-conversion
    for (int k = 0; k < 8; k++) vin[k] = 11'd900;
    vin[2] = 11'd100;
    wr_ctl(8'b0010_1010);
    repeat (3) @(negedge clk);
    wr_ctl(8'b0011_0110);
    chk("R9 sel_ch held", sel_ch, 2);
    n = 0; wait_done(n);
    chk("R9 result from held channel", {res_hi, res_lo}, 100);

    // R10 second start ignored
    vin[2] = 11'd777;
    wr_prs(8'd2);
    wr_ctl(8'b0010_1010);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    wr_ctl(8'b0010_1010);
    n += 2;
    wait_done(n);
    chk("R10 end time", n, 40);
    chk("R10 result", {res_hi, res_lo}, 777);

    // R11 reset mid-conversion
    wr_ctl(8'b0010_1010);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 ctl after reset", ctl_q, 0);
    chk("R11 res after reset", {res_hi, res_lo}, 0);
    chk("R11 prs after reset", prs_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule